// File: doc/BRIEF.md
# Byte-Wide Serial Peripheral Host with Write-Collision Detection

This block is a memory-mapped serial peripheral (SPI) host. Software programs a control register, then writes a byte to the data register. The block shifts that byte out on MOSI while it shifts a byte in from MISO, most significant bit first. The serial clock runs in any of the four polarity and phase combinations, at one of four divisions of the system clock. When a frame finishes, a completion flag is set. That flag can drive an interrupt line.

A second write to the data register while a frame is on the wire does not restart the frame. It is refused and recorded in a collision flag. Both flags are cleared by a two-step sequence. A status read records which flags were set at that moment. The next data-register access then clears exactly those flags, so a flag raised after the status read survives.

Register map (2-bit address): 0 is control, 1 is status, 2 is data, and 3 reads as zero. Control bits, from bit 7 down to bit 0:

| Bit | Field | Meaning |
|---|---|---|
| 7 | irq_en | interrupt enable |
| 6 | enable | system enable |
| 5 | wired_or | stored only |
| 4 | host_sel | stored only |
| 3 | cpol | clock polarity |
| 2 | cpha | clock phase |
| 1:0 | rate | clock rate select |

Status bits: 7 is the completion flag, 6 is the collision flag, and 4 is a reserved fault bit that always reads 0.

Top module: `spi_host_ctrl`

## Requirements
- R1: After reset, control, status and data all read 0, and sck, mosi and irq are 0.
- R2: Control (address 0) reads back the last value written to it. Writes to status (address 1) have no effect on the flags.
- R3: Rate field values 0, 1, 2 and 3 give an sck half-period of 1, 2, 8 and 16 clocks. The completion flag (status bit 7) reads 1 exactly 16 half-periods after the clock edge that accepted the data write.
- R4: Frames are 8 bits, MSB first. With cpha=0, each MOSI bit is valid at the leading (first) sck edge of its bit time. With cpha=1, each MOSI bit is valid at the trailing (second) edge. MISO is sampled on that same edge.
- R5: sck rests at the cpol level (control bit 3) whenever no frame is active, and it makes exactly 16 transitions per frame.
- R6: A data write while enable (control bit 6) is 0 starts no frame: sck does not move, no flag is set, and the received byte is unchanged.
- R7: A data write while a frame is active sets the collision flag (status bit 6). The written value is discarded, and the frame in progress completes with its original data.
- R8: The completion flag is set when a frame ends. irq is 1 exactly while the completion flag and irq_en (control bit 7) are both 1.
- R9: A status read that sees any flag set records that flag set. The next data-register access (a read, or a write while enabled) clears only the recorded flags. Without such a prior status read, a data access clears nothing.
- R10: A data read returns the last fully received byte, including while a later frame is still in progress.
- R11: Reset aborts an active frame: control returns to 0, sck returns to 0, and no completion flag appears afterwards.
- R12: Status bit 4 and bits 5 and 3..0 read 0, and address 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system clock |
| rst_n | input | 1 | asynchronous active-low reset |
| bus_sel | input | 1 | register access strobe for this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | register address |
| bus_wdata | input | 8 | write data |
| bus_rdata | output | 8 | read data for bus_addr (combinational) |
| sck | output | 1 | serial clock |
| mosi | output | 1 | serial data out |
| miso | input | 1 | serial data in |
| irq | output | 1 | interrupt request |

## Verification
The hardest state to reach is one where the recorded clear set and the live flags differ. This requires a collision, a status read taken while the frame is still running, and then the frame ending before the data access. The bench starts a slow frame, writes the data register a few cycles later, and reads status while the frame still runs, so that only the collision flag is recorded. It then waits past the end of the frame and shows that the data read clears the collision flag but leaves the completion flag set. MISO is looped back from MOSI, optionally inverted, so every one of the four clock modes can be checked for bit order and sampling edge without a separate serial model.

// File: rtl/spi_host_pkg.sv
package spi_host_pkg;

   localparam logic [1:0] ADDR_CTRL = 2'd0;
   localparam logic [1:0] ADDR_STAT = 2'd1;
   localparam logic [1:0] ADDR_DATA = 2'd2;

   // control layout, bit 7 down to bit 0
   typedef struct packed {
      logic       irq_en;
      logic       enable;
      logic       wired_or;
      logic       host_sel;
      logic       cpol;
      logic       cpha;
      logic [1:0] rate;
   } ctrl_t;

   function automatic int unsigned max4(input int unsigned a, b, c, d);
      int unsigned m;
      m = a;
      if (b > m) m = b;
      if (c > m) m = c;
      if (d > m) m = d;
      return m;
   endfunction

endpackage

// File: rtl/spi_host_clkdiv.sv
module spi_host_clkdiv #(
   parameter int unsigned HALF_R0 = 1,
   parameter int unsigned HALF_R1 = 2,
   parameter int unsigned HALF_R2 = 8,
   parameter int unsigned HALF_R3 = 16
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       run,
   input  logic [1:0] rate,
   output logic       edge_stb
);
   localparam int unsigned HALF_MAX = spi_host_pkg::max4(HALF_R0, HALF_R1, HALF_R2, HALF_R3);
   localparam int unsigned CNT_W    = $clog2(HALF_MAX + 1);
   localparam int unsigned HALF_TAB [4] = '{HALF_R0, HALF_R1, HALF_R2, HALF_R3};

   for (genvar g = 0; g < 4; g++) begin : g_half_chk
      if (HALF_TAB[g] < 1) begin : g_bad
         $error("half-period for rate %0d must be at least one clock", g);
      end
   end

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] half_m1;

   always_comb begin
      case (rate)
         2'd0:    half_m1 = CNT_W'(HALF_R0 - 1);
         2'd1:    half_m1 = CNT_W'(HALF_R1 - 1);
         2'd2:    half_m1 = CNT_W'(HALF_R2 - 1);
         default: half_m1 = CNT_W'(HALF_R3 - 1);
      endcase
   end

   assign edge_stb = run && (cnt_q >= half_m1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (!run || edge_stb) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

endmodule

// File: rtl/spi_host_shifter.sv
module spi_host_shifter #(
   parameter int unsigned FRAME_W = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic [FRAME_W-1:0] tx_byte,
   input  logic               cpha,
   input  logic               edge_stb,
   input  logic               miso,
   output logic               busy,
   output logic               sck_par,
   output logic               mosi,
   output logic               done,
   output logic [FRAME_W-1:0] rx_byte
);
   localparam int unsigned EDGES  = 2 * FRAME_W;
   localparam int unsigned EDGE_W = $clog2(EDGES);
   localparam logic [EDGE_W-1:0] LAST_EDGE = EDGE_W'(EDGES - 1);
   localparam logic [EDGE_W-1:0] PENULT    = EDGE_W'(EDGES - 2);

   if (FRAME_W < 2) begin : g_bad_frame
      $error("frame must hold at least two bits");
   end

   logic               busy_q;
   logic [EDGE_W-1:0]  edge_q;
   logic [FRAME_W-1:0] tx_sh;
   logic [FRAME_W-2:0] rx_sh;
   logic [FRAME_W-1:0] rx_hold;
   logic               mosi_q;

   logic lead, trail, last, sample, drive, final_sample;

   assign lead         = edge_stb && !edge_q[0];
   assign trail        = edge_stb &&  edge_q[0];
   assign last         = edge_stb && (edge_q == LAST_EDGE);
   assign sample       = cpha ? trail : lead;
   assign drive        = cpha ? lead  : (trail && !last);
   assign final_sample = sample && (edge_q >= PENULT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q  <= 1'b0;
         edge_q  <= '0;
         tx_sh   <= '0;
         rx_sh   <= '0;
         rx_hold <= '0;
         mosi_q  <= 1'b0;
      end else if (start) begin
         busy_q <= 1'b1;
         edge_q <= '0;
         rx_sh  <= '0;
         if (!cpha) begin
            mosi_q <= tx_byte[FRAME_W-1];
            tx_sh  <= tx_byte << 1;
         end else begin
            tx_sh  <= tx_byte;
         end
      end else if (busy_q && edge_stb) begin
         edge_q <= last ? '0 : edge_q + 1'b1;
         if (sample) begin
            if (final_sample) begin
               rx_hold <= {rx_sh, miso};
            end else begin
               rx_sh <= {rx_sh[FRAME_W-3:0], miso};
            end
         end
         if (drive) begin
            mosi_q <= tx_sh[FRAME_W-1];
            tx_sh  <= tx_sh << 1;
         end
         if (last) begin
            busy_q <= 1'b0;
         end
      end
   end

   assign busy    = busy_q;
   assign sck_par = edge_q[0];
   assign mosi    = mosi_q;
   assign done    = busy_q && last;
   assign rx_byte = rx_hold;

endmodule

// File: rtl/spi_host_regs.sv
module spi_host_regs
   import spi_host_pkg::*;
#(
   parameter int unsigned FRAME_W = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               bus_sel,
   input  logic               bus_wr,
   input  logic [1:0]         bus_addr,
   input  logic [FRAME_W-1:0] bus_wdata,
   input  logic               busy,
   input  logic               done,
   input  logic [FRAME_W-1:0] rx_byte,
   output logic [FRAME_W-1:0] bus_rdata,
   output logic               start,
   output logic               enable,
   output logic               irq_en,
   output logic               cpol,
   output logic               cpha,
   output logic [1:0]         rate,
   output logic               flag_done,
   output logic               flag_coll,
   output logic               irq
);
   if (FRAME_W < 8) begin : g_bad_width
      $error("register width must be at least eight bits");
   end

   ctrl_t ctrl_q;
   logic  done_q, coll_q;
   logic  arm_done_q, arm_coll_q;

   logic wr_ctrl, wr_data, rd_stat, rd_data;
   logic collide, data_touch;

   assign wr_ctrl    = bus_sel &&  bus_wr && (bus_addr == ADDR_CTRL);
   assign wr_data    = bus_sel &&  bus_wr && (bus_addr == ADDR_DATA);
   assign rd_stat    = bus_sel && !bus_wr && (bus_addr == ADDR_STAT);
   assign rd_data    = bus_sel && !bus_wr && (bus_addr == ADDR_DATA);
   assign start      = wr_data && ctrl_q.enable && !busy;
   assign collide    = wr_data && ctrl_q.enable &&  busy;
   assign data_touch = rd_data || (wr_data && ctrl_q.enable);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
      end else if (wr_ctrl) begin
         ctrl_q <= ctrl_t'(bus_wdata[7:0]);
      end
   end

   // flags: a set in the same cycle wins over the armed clear
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done_q <= 1'b0;
         coll_q <= 1'b0;
      end else begin
         done_q <= done    || (done_q && !(data_touch && arm_done_q));
         coll_q <= collide || (coll_q && !(data_touch && arm_coll_q));
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         arm_done_q <= 1'b0;
         arm_coll_q <= 1'b0;
      end else if (rd_stat && (done_q || coll_q)) begin
         arm_done_q <= done_q;
         arm_coll_q <= coll_q;
      end else if (data_touch) begin
         arm_done_q <= 1'b0;
         arm_coll_q <= 1'b0;
      end
   end

   always_comb begin
      case (bus_addr)
         ADDR_CTRL: bus_rdata = FRAME_W'(ctrl_q);
         ADDR_STAT: bus_rdata = FRAME_W'({done_q, coll_q, 1'b0, 1'b0, 4'b0000});
         ADDR_DATA: bus_rdata = rx_byte;
         default:   bus_rdata = '0;
      endcase
   end

   assign enable    = ctrl_q.enable;
   assign irq_en    = ctrl_q.irq_en;
   assign cpol      = ctrl_q.cpol;
   assign cpha      = ctrl_q.cpha;
   assign rate      = ctrl_q.rate;
   assign flag_done = done_q;
   assign flag_coll = coll_q;
   assign irq       = done_q && ctrl_q.irq_en;

endmodule

// File: rtl/spi_host_ctrl.sv
module spi_host_ctrl #(
   parameter int unsigned FRAME_W = 8,
   parameter int unsigned HALF_R0 = 1,
   parameter int unsigned HALF_R1 = 2,
   parameter int unsigned HALF_R2 = 8,
   parameter int unsigned HALF_R3 = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               bus_sel,
   input  logic               bus_wr,
   input  logic [1:0]         bus_addr,
   input  logic [FRAME_W-1:0] bus_wdata,
   output logic [FRAME_W-1:0] bus_rdata,
   output logic               sck,
   output logic               mosi,
   input  logic               miso,
   output logic               irq
);
   logic               start, busy, xfer_done, edge_stb, sck_par;
   logic               enable, irq_en, cpol, cpha;
   logic [1:0]         rate;
   logic               flag_done, flag_coll;
   logic [FRAME_W-1:0] rx_byte;

   spi_host_regs #(.FRAME_W(FRAME_W)) i_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_sel   (bus_sel),
      .bus_wr    (bus_wr),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .busy      (busy),
      .done      (xfer_done),
      .rx_byte   (rx_byte),
      .bus_rdata (bus_rdata),
      .start     (start),
      .enable    (enable),
      .irq_en    (irq_en),
      .cpol      (cpol),
      .cpha      (cpha),
      .rate      (rate),
      .flag_done (flag_done),
      .flag_coll (flag_coll),
      .irq       (irq)
   );

   spi_host_clkdiv #(
      .HALF_R0 (HALF_R0),
      .HALF_R1 (HALF_R1),
      .HALF_R2 (HALF_R2),
      .HALF_R3 (HALF_R3)
   ) i_clkdiv (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (busy),
      .rate     (rate),
      .edge_stb (edge_stb)
   );

   spi_host_shifter #(.FRAME_W(FRAME_W)) i_shifter (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .tx_byte  (bus_wdata),
      .cpha     (cpha),
      .edge_stb (edge_stb),
      .miso     (miso),
      .busy     (busy),
      .sck_par  (sck_par),
      .mosi     (mosi),
      .done     (xfer_done),
      .rx_byte  (rx_byte)
   );

   assign sck = cpol ^ (busy && sck_par);

endmodule

// File: rtl/spi_host_ctrl_chk.sv
module spi_host_ctrl_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       bus_sel,
   input logic       bus_wr,
   input logic [1:0] bus_addr,
   input logic       busy,
   input logic       xfer_done,
   input logic       enable,
   input logic       irq_en,
   input logic       cpol,
   input logic       flag_done,
   input logic       flag_coll,
   input logic       sck,
   input logic       irq
);
   logic data_wr, stat_wr;
   assign data_wr = bus_sel && bus_wr && (bus_addr == spi_host_pkg::ADDR_DATA);
   assign stat_wr = bus_sel && bus_wr && (bus_addr == spi_host_pkg::ADDR_STAT);

   AST_SCK_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (sck == cpol)); // R5

   AST_DONE_RAISES_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_done |=> flag_done); // R8

   AST_IRQ_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> ($rose(flag_done) || $rose(irq_en))); // R8

   AST_COLL_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
      (data_wr && enable && busy) |=> flag_coll); // R7

   AST_COLL_KEEPS_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
      (data_wr && enable && busy && !xfer_done) |=> busy); // R7

   AST_DISABLED_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
      (data_wr && !enable && !busy) |=> !busy); // R6

   AST_STAT_WRITE_INERT: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_wr && !xfer_done) |=> ($stable(flag_done) && $stable(flag_coll))); // R2

endmodule

bind spi_host_ctrl spi_host_ctrl_chk i_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_sel   (bus_sel),
   .bus_wr    (bus_wr),
   .bus_addr  (bus_addr),
   .busy      (busy),
   .xfer_done (xfer_done),
   .enable    (enable),
   .irq_en    (irq_en),
   .cpol      (cpol),
   .flag_done (flag_done),
   .flag_coll (flag_coll),
   .sck       (sck),
   .irq       (irq)
);

// File: tb/test_spi_host_ctrl.sv
module test_spi_host_ctrl;

   localparam logic [1:0] A_CTRL = 2'd0;
   localparam logic [1:0] A_STAT = 2'd1;
   localparam logic [1:0] A_DATA = 2'd2;

   // {control, tx byte, invert miso, expected rx, expected cycles}
   localparam logic [33:0] VEC [8] = '{
      {8'h40, 8'hA5, 1'b0, 8'hA5, 9'd16},
      {8'h49, 8'h3C, 1'b1, 8'hC3, 9'd32},
      {8'h46, 8'h81, 1'b0, 8'h81, 9'd128},
      {8'h4F, 8'h5E, 1'b1, 8'hA1, 9'd256},
      {8'hC4, 8'hFF, 1'b0, 8'hFF, 9'd16},
      {8'hC8, 8'h00, 1'b1, 8'hFF, 9'd16},
      {8'h4D, 8'h69, 1'b0, 8'h69, 9'd32},
      {8'h42, 8'h96, 1'b1, 8'h69, 9'd128}
   };

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bus_sel = 1'b0;
   logic       bus_wr = 1'b0;
   logic [1:0] bus_addr = 2'd0;
   logic [7:0] bus_wdata = 8'h00;
   logic [7:0] bus_rdata;
   logic       sck, mosi, miso, irq;

   logic       inv_q = 1'b0;
   logic       cur_cpol = 1'b0;
   logic       cur_cpha = 1'b0;
   logic       mon_en = 1'b0;
   int         toggles = 0;
   logic [7:0] cap = 8'h00;
   int         n_chk = 0;
   int         n_fail = 0;
   bit         finished = 1'b0;

   always #2 clk = ~clk;

   assign miso = mosi ^ inv_q;

   spi_host_ctrl i_spi_host_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_sel   (bus_sel),
      .bus_wr    (bus_wr),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .sck       (sck),
      .mosi      (mosi),
      .miso      (miso),
      .irq       (irq)
   );

   always @(sck) begin
      if (mon_en) begin
         toggles++;
         if ((sck !== cur_cpol) ^ cur_cpha) cap = {cap[6:0], mosi};
      end
   end

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
      #1 d = bus_rdata;
      @(negedge clk);
      bus_sel = 1'b0;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog actual=hung expected=complete");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      logic [7:0] r;
      int         n;
      int         sck_moves;
      logic       last_sck;

      idle(3);
      rst_n = 1'b1;
      // R1 reset state
      bus_read(A_CTRL, r); check("R1 ctrl", r, 8'h00);
      bus_read(A_STAT, r); check("R1 stat", r, 8'h00);
      bus_read(A_DATA, r); check("R1 data", r, 8'h00);
      check("R1 sck/mosi/irq", {sck, mosi, irq}, 3'b000);

      // R2 control readback, status write inert; R12 reserved bits
      bus_write(A_CTRL, 8'h3B);
      bus_read(A_CTRL, r); check("R2 ctrl readback", r, 8'h3B);
      check("R5 idle sck follows cpol", sck, 1'b1);
      bus_write(A_STAT, 8'hFF);
      bus_read(A_STAT, r); check("R2 R12 status after write", r, 8'h00);
      bus_read(2'd3, r); check("R12 unused address", r, 8'h00);

      // R6 disabled write starts nothing
      bus_write(A_DATA, 8'h77);
      sck_moves = 0; last_sck = sck;
      for (int i = 0; i < 50; i++) begin
         @(negedge clk);
         if (sck !== last_sck) sck_moves++;
         last_sck = sck;
      end
      check("R6 sck still", sck_moves, 0);
      bus_read(A_STAT, r); check("R6 no flag", r, 8'h00);
      bus_read(A_DATA, r); check("R6 rx unchanged", r, 8'h00);

      // table of frames across modes and rates: R3 R4 R5 R8 R9 R10
      for (int v = 0; v < 8; v++) begin
         logic [7:0] c, tx, erx;
         logic       inv;
         logic [8:0] ecyc;
         {c, tx, inv, erx, ecyc} = VEC[v];
         cur_cpol = c[3]; cur_cpha = c[2]; inv_q = inv;
         bus_write(A_CTRL, c);
         check("R5 idle level", sck, c[3]);
         toggles = 0; cap = 8'h00; mon_en = 1'b1;
         bus_write(A_DATA, tx);
         bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = A_STAT;
         n = 0;
         #1;
         while (bus_rdata[7] !== 1'b1 && n < 3000) begin
            @(negedge clk); #1; n++;
         end
         @(negedge clk);
         bus_sel = 1'b0; mon_en = 1'b0;
         check("R3 frame length", n, ecyc);
         check("R5 sck transitions", toggles, 16);
         check("R5 sck back to idle", sck, c[3]);
         check("R4 mosi bits at sample edge", cap, tx);
         check("R8 irq with enable", irq, c[7]);
         bus_read(A_DATA, r); check("R4 R10 received byte", r, erx);
         bus_read(A_STAT, r); check("R9 armed clear", r, 8'h00);
         check("R8 irq dropped", irq, 1'b0);
      end

      // R7 collision and R9 partial clear
      inv_q = 1'b0;
      bus_write(A_CTRL, 8'h41);
      bus_write(A_DATA, 8'hC6);
      idle(5);
      bus_write(A_DATA, 8'h11);
      bus_read(A_STAT, r); check("R7 collision flag", r, 8'h40);
      idle(40);
      bus_read(A_DATA, r); check("R7 frame undisturbed", r, 8'hC6);
      bus_read(A_STAT, r); check("R9 unrecorded flag kept", r, 8'h80);
      bus_read(A_DATA, r);
      bus_read(A_STAT, r); check("R9 recorded flag cleared", r, 8'h00);

      // R9 data access without prior status read clears nothing
      bus_write(A_DATA, 8'h5A);
      idle(40);
      bus_read(A_DATA, r); check("R10 rx after frame", r, 8'h5A);
      bus_read(A_STAT, r); check("R9 no arm no clear", r, 8'h80);
      bus_write(A_DATA, 8'h33);
      bus_read(A_STAT, r); check("R9 data write clears", r, 8'h00);
      idle(40);

      // R10 read mid-frame, R11 reset abort
      bus_write(A_CTRL, 8'h43);
      bus_write(A_DATA, 8'hE1);
      idle(20);
      bus_read(A_DATA, r); check("R10 previous byte mid-frame", r, 8'h33);
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk);
      check("R11 sck low in reset", sck, 1'b0);
      rst_n = 1'b1;
      bus_read(A_CTRL, r); check("R11 ctrl cleared", r, 8'h00);
      cur_cpol = 1'b0; toggles = 0; mon_en = 1'b1;
      idle(600);
      mon_en = 1'b0;
      check("R11 no clock after abort", toggles, 0);
      bus_read(A_STAT, r); check("R11 no completion", r, 8'h00);
      check("R11 irq low", irq, 1'b0);

      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule